// File: doc/BRIEF.md
# Serial Flash Whole-Array Erase Handler

This block is the command front end of a small serial flash model. It behaves as an SPI slave in mode 0 or mode 3, oversampling the serial clock, chip select and data input in the system clock domain. It keeps a write-enable latch and a busy flag. A parameterised register array stands in for the flash cells. A protection mask, one bit per region, comes from test inputs. A direct test read port exposes any byte of the array.

The host first sets the write-enable latch with opcode 06h. It then sends one of the two erase opcodes, 60h or C7h, as a frame of exactly eight bits, and the erase starts when chip select is released. If the latch is set and no region is protected, the block stays busy for a fixed number of clock cycles. At the end of that time every byte becomes FFh, and both busy and the latch clear. If the latch is clear or a region is protected, the erase is dropped and the latch is cleared. A status byte can be read with opcode 05h at any time, including during the erase. Opcode 04h clears the latch.

Top module: `flash_erase_top`

## Requirements
- R1: After reset the status byte reads 00h, the serial output enable is low, and array byte `a` holds `a & 7Fh`.
- R2: Opcode 06h sets the write-enable latch (status bit 1). Opcode 04h clears it.
- R3: Opcodes 60h and C7h, accepted with the latch set and no protection bit active, set every array byte to FFh when the erase completes. The latch clears at the same time.
- R4: An erase opcode received while the latch is clear changes nothing in the array and leaves busy low.
- R5: An erase opcode received while any bit of the protection mask is 1 is dropped. The array is unchanged, busy stays low, and the latch is cleared.
- R6: A command takes effect only when chip select rises after exactly eight bits. Frames of 7 or 9 bits have no effect.
- R7: An accepted erase holds status bit 0 (busy) at 1 for ERASE_CYCLES clock cycles. Until busy clears, the array keeps its old contents, and the latch reads 1 throughout.
- R8: While busy is set, every command other than the status read is ignored. A 04h sent during the erase leaves status bit 1 at 1.
- R9: Bits are shifted in most-significant first on rising clock edges. The block works the same with the serial clock idling low (mode 0) or high (mode 3).
- R10: Opcode 05h returns the status byte, most-significant bit first, on the eight clocks that follow it. The upper six bits of the status byte are 0. At all other times the serial output enable stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for miso_o; low means high impedance |
| prot_i | input | REGIONS | Per-region protection mask |
| test_addr_i | input | $clog2(DEPTH) | Test read address |
| test_data_o | output | 8 | Array byte at test_addr_i |

## Verification
The bench sends frames of 7 and 9 bits, which must be discarded. A design that counts only up to eight, or that acts on the first eight bits, would set the latch or start an erase. It sends an erase both with the latch clear and with a single protection bit set, where a careless design would wipe the array or leave the latch set. During an erase it reads status and sends 04h: an early array write, a busy flag that is not honoured, or a lost latch shows up as a wrong status byte or array byte. Each erase opcode runs in one of the two clock modes, and the output enable is compared against the model on every clock, which catches an output that drives outside a status read.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_ERA0 = 8'h60;
  localparam logic [7:0] OP_ERA1 = 8'hC7;
  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_WEL  = 1;

  typedef struct packed {
    logic       valid;
    logic [7:0] op;
  } cmd_t;

  function automatic logic is_erase(input logic [7:0] op);
    return (op == OP_ERA0) || (op == OP_ERA1);
  endfunction
endpackage

// File: rtl/flash_spi_front.sv
module flash_spi_front
  import flash_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  input  logic [7:0] status_i,
  output cmd_t       cmd_o,
  output logic       miso_o,
  output logic       miso_oe_o
);
  localparam int unsigned CNT_W   = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] sck_sync, cs_sync, mosi_sync;
  logic sck_s, cs_s, mosi_s, sck_d, cs_d;
  logic sck_rise, sck_fall, cs_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sync  <= '0;
      cs_sync   <= '1;
      mosi_sync <= '0;
      sck_d     <= 1'b0;
      cs_d      <= 1'b1;
    end else begin
      sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck_i};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_ni};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
      sck_d     <= sck_s;
      cs_d      <= cs_s;
    end
  end

  assign sck_s    = sck_sync[SYNC_STAGES-1];
  assign cs_s     = cs_sync[SYNC_STAGES-1];
  assign mosi_s   = mosi_sync[SYNC_STAGES-1];
  assign sck_rise = sck_s & ~sck_d & ~cs_s;
  assign sck_fall = ~sck_s & sck_d & ~cs_s;
  assign cs_rise  = cs_s & ~cs_d;

  logic [7:0]       shreg;
  logic [7:0]       shreg_nxt;
  logic [CNT_W-1:0] bit_cnt;
  logic             rd_pending, rd_active;
  logic [7:0]       tx_q;
  logic [2:0]       tx_cnt;

  assign shreg_nxt = {shreg[6:0], mosi_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (cs_s) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      shreg <= shreg_nxt;
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // frame completes on chip-select release with exactly eight bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o <= '0;
    end else begin
      cmd_o.valid <= cs_rise && (bit_cnt == CNT_W'(8));
      cmd_o.op    <= shreg;
    end
  end

  // status read: load on the falling edge after the eighth bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pending <= 1'b0;
      rd_active  <= 1'b0;
      tx_q       <= '0;
      tx_cnt     <= '0;
    end else if (cs_s) begin
      rd_pending <= 1'b0;
      rd_active  <= 1'b0;
    end else begin
      if (sck_rise && bit_cnt == CNT_W'(7) && shreg_nxt == OP_RDSR)
        rd_pending <= 1'b1;
      if (sck_fall) begin
        if (rd_pending) begin
          rd_pending <= 1'b0;
          rd_active  <= 1'b1;
          tx_q       <= status_i;
          tx_cnt     <= '0;
        end else if (rd_active) begin
          if (tx_cnt == 3'd7) begin
            tx_q   <= status_i;
            tx_cnt <= '0;
          end else begin
            tx_q   <= {tx_q[6:0], 1'b0};
            tx_cnt <= tx_cnt + 1'b1;
          end
        end
      end
    end
  end

  assign miso_o    = tx_q[7];
  assign miso_oe_o = rd_active & ~cs_s;

  // R6
  cmd_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o.valid |-> $past(cs_rise));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int unsigned REGIONS      = 4,
  parameter int unsigned ERASE_CYCLES = 200
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cmd_t               cmd_i,
  input  logic [REGIONS-1:0] prot_i,
  output logic [7:0]         status_o,
  output logic               erase_o
);
  localparam int unsigned CW = $clog2(ERASE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(ERASE_CYCLES - 1);

  logic          wel_q, busy_q;
  logic [CW-1:0] cnt_q;
  logic          cmd_ok, protected_any;

  assign protected_any = |prot_i;
  assign cmd_ok        = cmd_i.valid && !busy_q;
  assign erase_o       = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (erase_o) begin
        busy_q <= 1'b0;
        wel_q  <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (cmd_ok) begin
      if (cmd_i.op == OP_WREN) begin
        wel_q <= 1'b1;
      end else if (cmd_i.op == OP_WRDI) begin
        wel_q <= 1'b0;
      end else if (is_erase(cmd_i.op)) begin
        if (wel_q && !protected_any) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          wel_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_BUSY] = busy_q;
    status_o[ST_WEL]  = wel_q;
  end

  // R7
  busy_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> wel_q);
  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CW'(ERASE_CYCLES)));
  // R5
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ok && is_erase(cmd_i.op) && (!wel_q || protected_any)) |=> (!busy_q && !wel_q));
  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !erase_o) |=> (busy_q && wel_q));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_i,
  input  logic [AW-1:0] test_addr_i,
  output logic [7:0]    test_data_o
);
  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mem_q[g] <= 8'(g) & 8'h7F;
      else if (erase_i) mem_q[g] <= 8'hFF;
    end
  end

  assign test_data_o = mem_q[test_addr_i];

  // R3
  erase_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> (test_data_o == 8'hFF));
endmodule

// File: rtl/flash_erase_top.sv
module flash_erase_top
  import flash_pkg::*;
#(
  parameter int unsigned DEPTH        = 16,
  parameter int unsigned REGIONS      = 4,
  parameter int unsigned ERASE_CYCLES = 200,
  localparam int unsigned AW          = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               cs_ni,
  input  logic               mosi_i,
  output logic               miso_o,
  output logic               miso_oe_o,
  input  logic [REGIONS-1:0] prot_i,
  input  logic [AW-1:0]      test_addr_i,
  output logic [7:0]         test_data_o
);
  cmd_t       cmd;
  logic [7:0] status;
  logic       erase;

  flash_spi_front #(.SYNC_STAGES(2)) u_front (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .mosi_i,
    .status_i (status),
    .cmd_o    (cmd),
    .miso_o, .miso_oe_o
  );

  flash_cmd_ctrl #(.REGIONS(REGIONS), .ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_i    (cmd),
    .prot_i,
    .status_o (status),
    .erase_o  (erase)
  );

  flash_array #(.DEPTH(DEPTH)) u_array (
    .clk_i, .rst_ni,
    .erase_i (erase),
    .test_addr_i,
    .test_data_o
  );
endmodule

// File: tb/flash_erase_top_tb.sv
module flash_erase_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int DEPTH      = 16;
  localparam int REGIONS    = 4;
  localparam int ERASE_CYC  = 600;

  logic clk = 0, rst_ni = 0, sck = 0, cs_n = 1, mosi = 0;
  logic miso, miso_oe;
  logic [REGIONS-1:0] prot = '0;
  logic [3:0] taddr = '0;
  logic [7:0] tdata;

  int  n_cmp = 0, n_bad = 0;
  bit  mode3 = 0;
  bit  rd_phase = 0;
  bit  erased = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_top #(.DEPTH(DEPTH), .REGIONS(REGIONS), .ERASE_CYCLES(ERASE_CYC)) u_dut (
    .clk_i(clk), .rst_ni, .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .prot_i(prot),
    .test_addr_i(taddr), .test_data_o(tdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // R10: output enable compared against the model on every clock
  always @(negedge clk) begin
    if (rst_ni && !rd_phase) chk("R10 oe idle", {7'd0, miso_oe}, 8'h00);
  end

  function automatic logic [7:0] model_byte(input int a, input bit er);
    return er ? 8'hFF : (8'(a) & 8'h7F);
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] bits, input int n, output logic [7:0] rx);
    rx = '0;
    sck = mode3;
    wclk(2);
    cs_n = 0;
    wclk(4);
    for (int i = 0; i < n; i++) begin
      sck  = 0;
      mosi = bits[15-i];
      wclk(HALF);
      if (i >= 8) rx = {rx[6:0], miso};
      sck = 1;
      wclk(HALF);
    end
    if (!mode3) begin
      sck = 0;
      wclk(HALF);
    end
    cs_n = 1;
    wclk(10);
  endtask

  task automatic send(input logic [7:0] op, input int n);
    logic [7:0] d;
    frame({op, 8'h00}, n, d);
  endtask

  task automatic rd_status(output logic [7:0] s);
    rd_phase = 1;
    frame({8'h05, 8'h00}, 16, s);
    rd_phase = 0;
  endtask

  task automatic chk_array(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      taddr = 4'(a);
      wclk(1);
      chk(req, tdata, model_byte(a, erased));
    end
  endtask

  task automatic do_reset();
    rst_ni = 0;
    erased = 0;
    wclk(3);
    rst_ni = 1;
    wclk(3);
  endtask

  task automatic run_erase(input logic [7:0] op);
    logic [7:0] s;
    int polls;
    send(8'h06, 8);
    send(op, 8);
    rd_status(s);
    chk("R7 busy and latch", s, 8'h03);
    chk_array("R7 array held while busy");
    send(8'h04, 8);
    rd_status(s);
    chk("R8 latch kept while busy", s, 8'h03);
    polls = 0;
    do begin
      rd_status(s);
      polls++;
    end while (s[0] && polls < 20);
    chk("R7 busy clears in time", 8'(polls < 20), 8'h01);
    erased = 1;
    chk("R3 latch cleared at end", s, 8'h00);
    chk_array("R3 array all ones");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s;
    do_reset();
    // R1
    chk("R1 oe at reset", {7'd0, miso_oe}, 8'h00);
    rd_status(s);
    chk("R1 status at reset", s, 8'h00);
    chk_array("R1 array reset pattern");

    // R2
    send(8'h06, 8);
    rd_status(s);
    chk("R2 latch set", s, 8'h02);
    send(8'h04, 8);
    rd_status(s);
    chk("R2 latch cleared", s, 8'h00);

    // R4
    send(8'h60, 8);
    rd_status(s);
    chk("R4 erase without latch", s, 8'h00);
    chk_array("R4 array unchanged");

    // R5
    prot = 4'b0100;
    send(8'h06, 8);
    send(8'hC7, 8);
    rd_status(s);
    chk("R5 protected erase dropped", s, 8'h00);
    chk_array("R5 array unchanged");
    prot = '0;

    // R6
    send(8'h06, 7);
    rd_status(s);
    chk("R6 seven-bit frame", s, 8'h00);
    send(8'h06, 9);
    rd_status(s);
    chk("R6 nine-bit frame", s, 8'h00);
    send(8'h06, 8);
    send(8'h60, 9);
    rd_status(s);
    chk("R6 nine-bit erase", s, 8'h02);
    chk_array("R6 array unchanged");
    send(8'h04, 8);

    // R3 R7 R8 with 60h in mode 0
    run_erase(8'h60);

    // R9: mode 3 with C7h
    do_reset();
    mode3 = 1;
    sck = 1;
    wclk(4);
    rd_status(s);
    chk("R9 mode 3 status", s, 8'h00);
    run_erase(8'hC7);
    mode3 = 0;
    sck = 0;
    wclk(10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule